// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with Dual Routing

This block gathers 32 level-sensitive interrupt requests and presents them to a processor on two request lines. Every source has one bit in each register. A source reaches an output only when three things hold: its enable bit is set, its routing bit selects that output, and the top enable bit (bit 31), which acts as a global gate, is set. Software changes enable bits only through two strobe registers. One sets bits and the other clears bits, so a read-modify-write sequence is never needed.

The register bus is synchronous. A write takes an address, a write strobe and write data in one cycle. A read strobe with an address returns registered data on the following cycle. Software reads the unmasked input levels, the current enable mask, and one masked status word for each output. It reads these to find which source is pending. The requests are not latched: a request stays visible until its source drops it or software masks it.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset the enable mask and the routing register are all zero, and both request outputs are low.
- R2: A write to offset 0x34 sets the enable bits where the write data holds a one. All other enable bits keep their value.
- R3: A write to offset 0x38 clears the enable bits where the write data holds a one. All other enable bits keep their value, and writing all ones clears the whole mask.
- R4: Neither request output can be high while enable bit 31 is zero, whatever the other enable bits and inputs hold.
- R5: A routing bit (offset 0x20) of 0 steers its source to output 0, and a routing bit of 1 steers it to output 1. Output N is high when bit 31 is enabled and at least one source routed to N is both active and enabled.
- R6: Offset 0x00 reads raw AND enable AND NOT routing. Offset 0x04 reads raw AND enable AND routing.
- R7: Offset 0x30 reads the input levels after a two-flop synchronizer, with no masking applied. An input change reaches the raw status and the outputs on the second rising clock edge after it.
- R8: Requests are levels. When a source drops its request, its output contribution goes away after the same two-edge delay, with no acknowledge needed.
- R9: A read of 0x34 returns the enable mask. A read of 0x38 returns zero. Unmapped offsets read as zero, and a write to them leaves the mask and the routing register unchanged.
- R10: Read data appears on the cycle after the read strobe. It is zero on any cycle that does not follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | 32 | Level interrupt requests, one bit per source |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_req | output | 2 | Processor request lines, index = output number |

## Verification
The main test walks a single active source across all 32 positions. At each position the source is enabled, its routing bit alternates, and then the source is disabled. This run separates a fault in one bit lane from a fault in the routing polarity, and it separates status that leaks to the wrong word from status that is missing. Separate dense patterns drive every input high while the set and clear strobes are applied to overlapping masks. These patterns show whether the strobes disturb bits they do not target, and whether the global gate blocks an otherwise fully enabled controller. A timed toggle of one input checks the two-edge delay in both directions. This shows that the outputs follow the levels and are never latched.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int N_OUT  = 2;
    localparam int GATE_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] OFS_STAT0 = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_STAT1 = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_ROUTE = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_RAW   = 8'h30;
    localparam logic [ADDR_W-1:0] OFS_ENSET = 8'h34;
    localparam logic [ADDR_W-1:0] OFS_ENCLR = 8'h38;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_STAT0, SEL_STAT1, SEL_ROUTE, SEL_RAW, SEL_ENSET, SEL_ENCLR
    } sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] raw;
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] route;
    } irq_view_t;

    function automatic sel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_STAT0: return SEL_STAT0;
            OFS_STAT1: return SEL_STAT1;
            OFS_ROUTE: return SEL_ROUTE;
            OFS_RAW:   return SEL_RAW;
            OFS_ENSET: return SEL_ENSET;
            OFS_ENCLR: return SEL_ENCLR;
            default:   return SEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;
    logic [W-1:0] stage2;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            stage2 <= '0;
        end else begin
            stage1 <= d;
            stage2 <= stage1;
        end
    end

    assign q = stage2;
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  sel_e         sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] en_q,
    output logic [W-1:0] route_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            route_q <= '0;
        end else if (wr) begin
            case (sel)
                SEL_ENSET: en_q    <= en_q | wdata;
                SEL_ENCLR: en_q    <= en_q & ~wdata;
                SEL_ROUTE: route_q <= wdata;
                default: ;
            endcase
        end
    end

    // R2: every written one is set afterwards
    p_set_hits_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ENSET) |=> ((en_q & $past(wdata)) == $past(wdata)));
    // R2: bits written as zero keep their value
    p_set_keeps_r2: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ENSET) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));
    // R3: every written one is cleared afterwards
    p_clr_hits_r3: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_ENCLR) |=> ((en_q & $past(wdata)) == '0));
    // R9: unmapped writes change nothing
    p_unmapped_wr_r9: assert property (@(posedge clk) disable iff (rst)
        (wr && sel == SEL_NONE) |=> ($stable(en_q) && $stable(route_q)));
endmodule

// File: rtl/irqc_route.sv
module irqc_route
    import irqc_pkg::*;
#(
    parameter int W    = DATA_W,
    parameter int NO   = N_OUT,
    parameter int GBIT = W - 1
) (
    input  irq_view_t            view,
    output logic [NO-1:0][W-1:0] status,
    output logic [NO-1:0]        req
);
    localparam int SEL_W = (NO > 1) ? $clog2(NO) : 1;

    logic gate;
    assign gate = view.en[GBIT];

    for (genvar o = 0; o < NO; o++) begin : g_out
        logic [W-1:0] mine;
        always_comb begin
            for (int b = 0; b < W; b++) begin
                mine[b] = (SEL_W'(view.route[b]) == SEL_W'(o));
            end
        end
        assign status[o] = view.raw & view.en & mine;
        assign req[o]    = gate & (|status[o]);
    end
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] irq_src,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_OUT-1:0]  irq_req
);
    sel_e                          sel;
    logic [DATA_W-1:0]             raw_q;
    logic [DATA_W-1:0]             en_q;
    logic [DATA_W-1:0]             route_q;
    irq_view_t                     view;
    logic [N_OUT-1:0][DATA_W-1:0]  status;

    assign sel = decode(bus_addr);

    irqc_sync #(.W(DATA_W)) u_sync (
        .clk(clk), .rst(rst), .d(irq_src), .q(raw_q)
    );

    irqc_regs #(.W(DATA_W)) u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
        .en_q(en_q), .route_q(route_q)
    );

    assign view = '{raw: raw_q, en: en_q, route: route_q};

    irqc_route #(.W(DATA_W), .NO(N_OUT), .GBIT(GATE_BIT)) u_route (
        .view(view), .status(status), .req(irq_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            case (sel)
                SEL_STAT0: bus_rdata <= status[0];
                SEL_STAT1: bus_rdata <= status[1];
                SEL_ROUTE: bus_rdata <= route_q;
                SEL_RAW:   bus_rdata <= raw_q;
                SEL_ENSET: bus_rdata <= en_q;
                default:   bus_rdata <= '0;
            endcase
        end else begin
            bus_rdata <= '0;
        end
    end

    // R4: global gate blocks both outputs
    p_gate_blocks_r4: assert property (@(posedge clk) disable iff (rst)
        !en_q[GATE_BIT] |-> (irq_req == '0));
    // R5: a raised output has a pending, enabled source routed to it
    p_out1_source_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req[1] |-> ((raw_q & en_q & route_q) != '0));
    p_out0_source_r5: assert property (@(posedge clk) disable iff (rst)
        irq_req[0] |-> ((raw_q & en_q & ~route_q) != '0));
    // R10: no read strobe, no data
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> (bus_rdata == '0));
    // R9: unmapped and clear-strobe reads return zero
    p_blank_read_r9: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && (sel == SEL_NONE || sel == SEL_ENCLR)) |=> (bus_rdata == '0));
endmodule

// File: tb/sim_lvl_irq_ctrl.sv
module sim_lvl_irq_ctrl;
    logic        clk = 0;
    logic        rst = 1;
    logic [31:0] irq_src = '0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 0;
    logic [31:0] bus_rdata;
    logic [1:0]  irq_req;

    int checks = 0;
    int fails  = 0;
    logic [31:0] en_m = '0;
    logic [31:0] ty_m = '0;
    logic [31:0] rd_v;

    always #10 clk = ~clk;

    lvl_irq_ctrl u0 (
        .clk(clk), .rst(rst), .irq_src(irq_src), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq_req(irq_req)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0;
        if (a == 8'h34) en_m = en_m | d;
        if (a == 8'h38) en_m = en_m & ~d;
        if (a == 8'h20) ty_m = d;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic drive_src(input logic [31:0] s);
        irq_src = s;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [1:0] exp_req();
        logic [31:0] s0 = irq_src & en_m & ~ty_m;
        logic [31:0] s1 = irq_src & en_m & ty_m;
        return en_m[31] ? {|s1, |s0} : 2'b00;
    endfunction

    task automatic chk_all(input string req);
        logic [31:0] v;
        chk(req, {30'd0, irq_req}, {30'd0, exp_req()});
        rd(8'h00, v); chk(req, v, irq_src & en_m & ~ty_m);
        rd(8'h04, v); chk(req, v, irq_src & en_m & ty_m);
    endtask

    initial begin
        #(200000 * 20);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 outputs", {30'd0, irq_req}, 32'd0);
        rd(8'h34, rd_v); chk("R1 mask", rd_v, 32'd0);
        rd(8'h20, rd_v); chk("R1 route", rd_v, 32'd0);

        // R5 R6 R7 walking source with alternating routing
        for (int i = 0; i < 32; i++) begin
            drive_src(32'd1 << i);
            rd(8'h30, rd_v); chk("R7 raw", rd_v, 32'd1 << i);
            wr(8'h20, (i % 2 == 1) ? (32'd1 << i) : 32'd0);
            wr(8'h34, (32'd1 << i) | 32'h8000_0000);
            chk_all("R5 R6 walk");
            if (i != 31) begin
                wr(8'h38, 32'd1 << i);
                chk("R3 clear one", {30'd0, irq_req}, 32'd0);
            end
            wr(8'h38, 32'hFFFF_FFFF);
            rd(8'h34, rd_v); chk("R3 all ones", rd_v, 32'd0);
        end

        // R2 R3 overlapping masks
        wr(8'h34, 32'h0000_00F0);
        wr(8'h34, 32'h0000_0F00);
        rd(8'h34, rd_v); chk("R2 set keeps", rd_v, 32'h0000_0FF0);
        wr(8'h38, 32'h0000_0030);
        rd(8'h34, rd_v); chk("R3 clear keeps", rd_v, 32'h0000_0FC0);

        // R4 global gate with everything pending
        wr(8'h20, 32'h5555_5555);
        drive_src(32'hFFFF_FFFF);
        wr(8'h34, 32'h7FFF_FFFF);
        chk_all("R4 gate off");
        chk("R4 no req", {30'd0, irq_req}, 32'd0);
        wr(8'h34, 32'h8000_0000);
        chk_all("R4 gate on");
        chk("R4 both req", {30'd0, irq_req}, 32'd3);
        wr(8'h20, 32'h0000_0000);
        chk_all("R5 all to out0");

        // R9 read/write corner offsets
        rd(8'h38, rd_v); chk("R9 clr reads zero", rd_v, 32'd0);
        rd(8'h10, rd_v); chk("R9 unmapped read", rd_v, 32'd0);
        wr(8'h24, 32'hFFFF_FFFF);
        wr(8'h3C, 32'hFFFF_FFFF);
        rd(8'h34, rd_v); chk("R9 unmapped write mask", rd_v, en_m);
        rd(8'h20, rd_v); chk("R9 unmapped write route", rd_v, 32'd0);

        // R10 read data only after strobe
        bus_addr = 8'h34;
        @(negedge clk);
        chk("R10 idle zero", bus_rdata, 32'd0);

        // R7 R8 latency and level behaviour
        wr(8'h38, 32'hFFFF_FFFF);
        drive_src(32'd0);
        wr(8'h34, 32'h8000_0008);
        irq_src = 32'h8;
        @(negedge clk);
        chk("R7 one edge", {30'd0, irq_req}, 32'd0);
        @(negedge clk);
        chk("R7 two edges", {30'd0, irq_req}, 32'd1);
        irq_src = 32'h0;
        @(negedge clk);
        chk("R8 held one edge", {30'd0, irq_req}, 32'd1);
        @(negedge clk);
        chk("R8 dropped", {30'd0, irq_req}, 32'd0);

        // R1 reset again clears state
        rst = 1;
        @(negedge clk);
        rst = 0;
        en_m = '0; ty_m = '0;
        rd(8'h34, rd_v); chk("R1 mask after reset", rd_v, 32'd0);

        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule